// File: doc/BRIEF.md
# Software Transfer Activation Register

This block is an 8-bit, CPU-accessible control register that lets software start a data-transfer controller. The upper bit is an activation enable. The lower seven bits choose an activation vector. From the vector the block forms the address at which the controller finds its transfer descriptor: a fixed base of 0x0400 plus twice the vector number.

Clearing the enable bit is guarded. Software can always set it. A software write of 0 clears it only when a register read has returned the enable set, and no write has come in between.

The transfer controller reports three things about each software-started transfer: whether it is running, when it finishes, and two qualifiers (disable-interrupt select and count-ended). From these the block decides whether the enable bit clears itself or holds. A request output tells the controller that a new activation is pending. Reset and a hardware standby input both return the register to 0x00.

Top module: `swact_ctrl`

## Requirements
- R1: After reset, and in the cycle after `standby_i` is high, the register reads 0x00, `act_req_o` is low and `vec_addr_o` is 0x0400.
- R2: A write with bit 7 = 1 sets the enable bit. This happens regardless of earlier reads and of any concurrent completion report.
- R3: A write with bit 7 = 0 leaves the enable bit unchanged unless a qualifying read came first. A qualifying read is a read whose returned bit 7 was 1, with no write since.
- R4: A write with bit 7 = 0 that follows a qualifying read clears the enable bit. Every write consumes the qualification, so a later write of 0 needs a fresh read of 1.
- R5: Bits 6..0 take the written value on every write and read back unchanged.
- R6: When `xfer_done_i` pulses with `irq_dis_sel_i` = 0 and `cnt_end_i` = 0, the enable bit is 0 in the next cycle.
- R7: The enable bit holds its value in three cases: on a completion with `irq_dis_sel_i` = 1, on a completion with `cnt_end_i` = 1, and for the whole time `xfer_busy_i` is high without a completion.
- R8: `vec_addr_o` always equals 0x0400 + 2 × (bits 6..0).
- R9: Consider a write with bit 7 = 1 while `xfer_busy_i` is low. From the next cycle `act_req_o` is high, until a cycle with `req_ack_i` high. After that it stays low until the next write of 1, even though the enable bit stays at 1. While `xfer_busy_i` is high, `act_req_o` is low.
- R10: A write with bit 7 = 1 in the same cycle as a clearing completion (the condition of R6) leaves the enable bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Hardware standby, synchronously forces register to 0x00 |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data: bit 7 enable, bits 6..0 vector |
| reg_rdata_o | output | 8 | Current register contents |
| xfer_busy_i | input | 1 | Software-started transfer in progress |
| xfer_done_i | input | 1 | One-cycle pulse at the end of a software-started transfer |
| irq_dis_sel_i | input | 1 | Disable-interrupt select for the finishing transfer |
| cnt_end_i | input | 1 | Programmed transfer count has ended |
| req_ack_i | input | 1 | Controller accepts the activation request |
| act_req_o | output | 1 | Activation request to the controller |
| vec_addr_o | output | 16 | Descriptor vector address |

## Verification
The bench builds the block with its defaults: a 7-bit vector and a 16-bit address. Writing every one of the 128 vector numbers, with the enable bit both set and clear, puts the whole readback and address map within reach of an arithmetic check. Those sweeps also cover the guard rule for every vector. Every combination of the two completion qualifiers is applied as well, together with a busy window, concurrent write and completion, and the request handshake.

// File: rtl/swact_pkg.sv
package swact_pkg;
  localparam int unsigned VEC_W  = 7;
  localparam int unsigned REG_W  = VEC_W + 1;
  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] VEC_BASE = 16'h0400;
endpackage

// File: rtl/swact_guard.sv
// Sticky qualification: a read that returned enable=1, consumed by any write.
module swact_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic en_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (standby_i)  armed_q <= 1'b0;
    else if (wr_i)       armed_q <= 1'b0;
    else if (rd_i && en_i) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  assert_write_consumes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !armed_q);
endmodule

// File: rtl/swact_enable.sv
module swact_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic armed_i,
  input  logic done_i,
  input  logic dis_sel_i,
  input  logic cnt_end_i,
  output logic en_o
);
  logic en_q, en_d, hw_clr;

  assign hw_clr = done_i && !dis_sel_i && !cnt_end_i;

  always_comb begin
    en_d = en_q;
    if (hw_clr) en_d = 1'b0;
    if (wr_i) begin
      if (wbit_i)       en_d = 1'b1;   // set always wins
      else if (armed_i) en_d = 1'b0;
    end
    if (standby_i) en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  assert_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wbit_i && !standby_i) |=> en_q);
  assert_unguarded_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wbit_i && !armed_i && !done_i && !standby_i) |=> $stable(en_q));
  assert_hold_cases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (dis_sel_i || cnt_end_i) && !wr_i && !standby_i) |=> $stable(en_q));
  assert_auto_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !dis_sel_i && !cnt_end_i && !(wr_i && wbit_i)) |=> !en_q);
  assert_fall_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> $past(standby_i || done_i || (wr_i && armed_i)));
endmodule

// File: rtl/swact_req.sv
module swact_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic set_i,
  input  logic ack_i,
  input  logic en_i,
  input  logic busy_i,
  output logic req_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (standby_i) pend_q <= 1'b0;
    else if (set_i)     pend_q <= 1'b1;
    else if (ack_i || !en_i) pend_q <= 1'b0;
  end

  assign req_o = pend_q && en_i && !busy_i;

  assert_ack_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !req_o);
endmodule

// File: rtl/swact_ctrl.sv
module swact_ctrl
  import swact_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              xfer_busy_i,
  input  logic              xfer_done_i,
  input  logic              irq_dis_sel_i,
  input  logic              cnt_end_i,
  input  logic              req_ack_i,
  output logic              act_req_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic             en, armed;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vec_q <= '0;
    else if (standby_i) vec_q <= '0;
    else if (reg_wr_i)  vec_q <= reg_wdata_i[VEC_W-1:0];
  end

  swact_guard u_guard (
    .clk_i, .rst_ni, .standby_i,
    .rd_i(reg_rd_i), .wr_i(reg_wr_i), .en_i(en), .armed_o(armed)
  );

  swact_enable u_enable (
    .clk_i, .rst_ni, .standby_i,
    .wr_i(reg_wr_i), .wbit_i(reg_wdata_i[REG_W-1]), .armed_i(armed),
    .done_i(xfer_done_i), .dis_sel_i(irq_dis_sel_i), .cnt_end_i(cnt_end_i),
    .en_o(en)
  );

  swact_req u_req (
    .clk_i, .rst_ni, .standby_i,
    .set_i(reg_wr_i && reg_wdata_i[REG_W-1]), .ack_i(req_ack_i),
    .en_i(en), .busy_i(xfer_busy_i), .req_o(act_req_o)
  );

  assign reg_rdata_o = {en, vec_q};
  assign vec_addr_o  = VEC_BASE + ADDR_W'({vec_q, 1'b0});

  assert_req_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_req_o |-> (reg_rdata_o[REG_W-1] && !xfer_busy_i));
  assert_vec_written_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !standby_i) |=> (reg_rdata_o[VEC_W-1:0] == $past(reg_wdata_i[VEC_W-1:0])));
  assert_standby_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (reg_rdata_o == '0 && !act_req_o));
  always_comb begin
    if (rst_ni) assert_addr_even_R8: assert (vec_addr_o[0] == 1'b0 && vec_addr_o >= VEC_BASE);
  end
endmodule

// File: tb/swact_ctrl_bench.sv
module swact_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy = 1'b0, done = 1'b0, dsel = 1'b0, cend = 1'b0, ack = 1'b0;
  logic        req;
  logic [15:0] vaddr;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  swact_ctrl u_swact_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .xfer_busy_i(busy), .xfer_done_i(done), .irq_dis_sel_i(dsel),
    .cnt_end_i(cend), .req_ack_i(ack), .act_req_o(req), .vec_addr_o(vaddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // read: rdata is combinational, checked before the edge that updates the guard
  task automatic do_rd(input string tag, input logic [7:0] exp);
    @(negedge clk); rd = 1'b1;
    #1 chk(tag, rdata, exp);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_done(input logic ds, input logic ce);
    @(negedge clk); done = 1'b1; dsel = ds; cend = ce;
    @(negedge clk); done = 1'b0; dsel = 1'b0; cend = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 req", req, 0);
    chk("R1 addr", vaddr, 16'h0400);

    // R5/R8 sweep of every vector, enable clear then set; R2 set
    for (int v = 0; v < 128; v++) begin
      do_wr(8'(v));
      #1 chk("R5 vec", rdata, 8'(v));
      chk("R8 addr", vaddr, 16'h0400 + 16'(v) * 2);
      do_wr(8'h80 | 8'(v));
      #1 chk("R2 set", rdata, 8'h80 | 8'(v));
      // R3 unguarded zero write keeps enable, vector still updates
      do_wr(8'(127 - v));
      #1 chk("R3 unguarded", rdata, 8'h80 | 8'(127 - v));
      // R4 qualifying read then zero write clears
      do_rd("R4 read", 8'h80 | 8'(127 - v));
      do_wr(8'(v));
      #1 chk("R4 guarded clear", rdata, 8'(v));
    end

    // R4 consumption: read, write 1 (consumes), then 0 is ignored
    do_wr(8'h81);
    do_rd("R4 read2", 8'h81);
    do_wr(8'h82);
    do_wr(8'h03);
    #1 chk("R4 consumed", rdata, 8'h83);

    // R3 read returning 0 does not qualify
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    #1 chk("R1 standby", rdata, 8'h00);
    chk("R1 standby addr", vaddr, 16'h0400);
    do_rd("R3 read zero", 8'h00);
    do_done(1'b0, 1'b1);
    do_wr(8'h00);
    #1 chk("R3 read0 idle", rdata, 8'h00);

    // R6 auto clear / R7 hold for all qualifier combos
    for (int c = 0; c < 4; c++) begin
      do_wr(8'h85);
      do_done(c[0], c[1]);
      #1 chk(c == 0 ? "R6 auto clear" : "R7 hold", rdata, c == 0 ? 8'h05 : 8'h85);
    end

    // R7 busy window holds enable, no request while busy (R9)
    do_wr(8'h86);
    @(negedge clk); busy = 1'b1;
    repeat (5) @(negedge clk);
    #1 chk("R7 busy hold", rdata, 8'h86);
    chk("R9 no req busy", req, 0);
    busy = 1'b0;

    // R9 handshake
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    do_wr(8'h87);
    #1 chk("R9 req up", req, 1);
    @(negedge clk); #1 chk("R9 req held", req, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1 chk("R9 req after ack", req, 0);
    do_done(1'b1, 1'b0);
    #1 chk("R9 no rerequest", req, 0);
    chk("R9 enable still", rdata, 8'h87);

    // R10 write 1 with clearing completion
    @(negedge clk); wr = 1'b1; wdata = 8'h88; done = 1'b1;
    @(negedge clk); wr = 1'b0; done = 1'b0;
    #1 chk("R10 set wins", rdata, 8'h88);
    do_done(1'b0, 1'b0);
    #1 chk("R10 next clear", rdata, 8'h08);

    summary();
  end
endmodule